// File: doc/BRIEF.md
# Paired-Halfword Management Register Bridge

This block is a management-bus slave that listens on an MDC/MDIO line and gives a host reach into a bank of 32-bit internal registers using ordinary 16-bit clause 22 style management frames. Each register is reached as two halves. The least significant bit of the 5-bit frame register field picks the half, where 0 is bits 15:0 and 1 is bits 31:16. The upper four bits of that field form the dword index presented on the internal register port.

The block merges writes so that the internal register sees one atomic 32-bit store. This store is issued only once both halves have arrived, and they may arrive in either order. Reads are made coherent in the same way. The first half of a read pair samples the whole dword into a latch, and the opposite half is then answered from that latch, so a value that moves between the two frames cannot tear.

A reset-in-progress input blanks the bridge while the chip initialises. It also discards any half-finished pair. MDC and MDIO are oversampled by the block clock, which must run several times faster than MDC.

Top module: `mdio_dword_bridge`

## Requirements
- R1: A frame is at least 32 ones, the start bits `01`, a 2-bit opcode (`10` read, `01` write), a 5-bit PHY address equal to parameter PHY_ADDR, a 5-bit register field, 2 turnaround bits and 16 data bits. All fields are msb first and sampled on MDC rising edges.
- R2: A frame with a bad start pattern, an opcode of `00` or `11`, or a foreign PHY address causes no MDIO drive and no register access. Decoding resumes only after a further run of at least 32 ones. While no frame is being answered, mdio_oe is low.
- R3: During a write frame, mdio_oe stays low.
- R4: Register field bit 0 selects the half (0 low, 1 high) and bits 4:1 the dword index. A write to one half followed by a write to the other half, in either order, produces exactly one single-clock reg_wr pulse. That pulse carries the merged 32-bit value and the index of the completing frame.
- R5: If a pending half is followed by a write to the same half, that second transfer is discarded. The pending half keeps its first value.
- R6: On a read, the first turnaround bit is left undriven and the second is driven to 0. The 16 data bits follow, each launched after an MDC falling edge. MDIO is released at the falling edge after the last data bit.
- R7: The first read of a pair pulses reg_rd once and latches the full dword. A read of the opposite half is served from the latch without touching the port. A repeated read of the same half starts a new pair.
- R8: When reg_valid is low at capture, the read returns all zeros and MDIO is still driven.
- R9: While reset_active is high, reads return zeros, writes are discarded, and neither reg_rd nor reg_wr pulses. Both pair trackers are cleared, so the next access after reset is a first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples MDC |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_active | input | 1 | Chip reset in progress |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | MDIO line as seen by the slave |
| mdio_o | output | 1 | MDIO value driven by the slave |
| mdio_oe | output | 1 | MDIO output enable |
| reg_idx | output | 4 | Dword index for the internal register port |
| reg_rd | output | 1 | Single-clock read strobe; reg_rdata sampled in that cycle |
| reg_rdata | input | 32 | Read data for reg_idx |
| reg_valid | input | 1 | reg_idx names an implemented register |
| reg_wr | output | 1 | Single-clock write strobe |
| reg_wdata | output | 32 | Merged write data |

## Verification
Two events can coincide. The reset-in-progress input can fall in the gap between the two halves of a pair, and that same pair then completes. The bench first reads one half and then pulses reset. It then rewrites the register and reads the opposite half, and it expects the freshly written value instead of the stale latch. A write pair split by a reset pulse is judged the same way: the half sent after reset must count as a first half. A counter register whose two halves always match shows whether each read pair was taken as one coherent snapshot.

// File: rtl/mdio_dword_bridge.sv
module mdio_dword_bridge #(
  parameter logic [4:0] PHY_ADDR = 5'd1,
  parameter int         PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reset_active,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [3:0]  reg_idx,
  output logic        reg_rd,
  input  logic [31:0] reg_rdata,
  input  logic        reg_valid,
  output logic        reg_wr,
  output logic [31:0] reg_wdata
);

  localparam int PW = $clog2(PRE_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_TA, S_WDATA, S_RDATA} st_t;

  st_t         st;
  logic        m1, m2, d1;
  logic [PW-1:0] pre_cnt;
  logic [4:0]  cnt;
  logic [11:0] hdr;
  logic        is_rd, half, rd_load;
  logic [15:0] wsh, wbuf;
  logic [16:0] rsh;
  logic        wpend, whalf, rpend, rhalf;
  logic [31:0] rlatch;

  wire rise = m1 & ~m2;
  wire fall = ~m1 & m2;
  wire [11:0] hdr_n = {hdr[10:0], d1};
  wire [15:0] wd_n  = {wsh[14:0], d1};
  wire        hdr_ok = (hdr_n[11:10] == 2'b10 || hdr_n[11:10] == 2'b01) &&
                       hdr_n[9:5] == PHY_ADDR;
  wire [31:0] snap  = reg_valid ? reg_rdata : 32'h0;
  wire        from_latch = rpend & (rhalf != half);

  assign reg_rd = rd_load & ~reset_active & ~from_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      m1 <= 1'b1; m2 <= 1'b1; d1 <= 1'b1;
      pre_cnt <= '0; cnt <= '0; hdr <= '0;
      is_rd <= 1'b0; half <= 1'b0; rd_load <= 1'b0;
      wsh <= '0; wbuf <= '0; rsh <= '0;
      wpend <= 1'b0; whalf <= 1'b0; rpend <= 1'b0; rhalf <= 1'b0;
      rlatch <= '0;
      mdio_o <= 1'b0; mdio_oe <= 1'b0;
      reg_idx <= '0; reg_wr <= 1'b0; reg_wdata <= '0;
    end else begin
      m1 <= mdc; m2 <= m1; d1 <= mdio_i;
      reg_wr <= 1'b0;

      if (rd_load) begin
        rd_load <= 1'b0;
        if (reset_active) begin
          rsh <= '0;
        end else if (from_latch) begin
          rsh   <= {1'b0, half ? rlatch[31:16] : rlatch[15:0]};
          rpend <= 1'b0;
        end else begin
          rlatch <= snap;
          rsh    <= {1'b0, half ? snap[31:16] : snap[15:0]};
          rpend  <= 1'b1;
          rhalf  <= half;
        end
      end

      case (st)
        S_IDLE: if (rise) begin
          if (d1) begin
            if (pre_cnt != PW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt == PW'(PRE_LEN)) begin
            st <= S_START;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= '0;
          end
        end
        S_START: if (rise) begin
          cnt <= '0;
          st  <= d1 ? S_HDR : S_IDLE;
        end
        S_HDR: if (rise) begin
          hdr <= hdr_n;
          cnt <= cnt + 1'b1;
          if (cnt == 5'd11) begin
            cnt <= '0;
            if (hdr_ok) begin
              st      <= S_TA;
              is_rd   <= hdr_n[11];
              half    <= hdr_n[0];
              reg_idx <= hdr_n[4:1];
              rd_load <= hdr_n[11];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_TA: if (rise) begin
          cnt <= cnt + 1'b1;
          if (is_rd) begin
            st <= S_RDATA;
            cnt <= '0;
          end else if (cnt == 5'd1) begin
            st <= S_WDATA;
            cnt <= '0;
          end
        end
        S_WDATA: if (rise) begin
          wsh <= wd_n;
          cnt <= cnt + 1'b1;
          if (cnt == 5'd15) begin
            st <= S_IDLE;
            if (!reset_active) begin
              if (!wpend) begin
                wbuf  <= wd_n;
                whalf <= half;
                wpend <= 1'b1;
              end else if (whalf != half) begin
                reg_wr    <= 1'b1;
                reg_wdata <= half ? {wd_n, wbuf} : {wbuf, wd_n};
                wpend     <= 1'b0;
              end
            end
          end
        end
        S_RDATA: if (fall) begin
          if (cnt < 5'd17) begin
            mdio_oe <= 1'b1;
            mdio_o  <= rsh[16];
            rsh     <= {rsh[15:0], 1'b0};
            cnt     <= cnt + 1'b1;
          end else begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (reset_active) begin
        wpend <= 1'b0;
        rpend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdio_dword_bridge_chk.sv
module mdio_dword_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic reset_active,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_rd,
  input logic reg_wr,
  input logic in_idle,
  input logic wr_frame
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !mdio_oe);

  p_no_drive_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frame |-> !mdio_oe);

  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_ta_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_active |-> (!reg_rd && !reg_wr));

endmodule

bind mdio_dword_bridge mdio_dword_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reset_active (reset_active),
  .mdio_o       (mdio_o),
  .mdio_oe      (mdio_oe),
  .reg_rd       (reg_rd),
  .reg_wr       (reg_wr),
  .in_idle      (st == S_IDLE),
  .wr_frame     (st == S_WDATA || (st == S_TA && !is_rd))
);

// File: tb/mdio_dword_bridge_tb.sv
`timescale 1ns/1ps
module mdio_dword_bridge_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, reset_active = 1'b0;
  logic        mdc = 1'b1, mdio_i = 1'b1;
  logic        mdio_o, mdio_oe, reg_rd, reg_wr, reg_valid;
  logic [3:0]  reg_idx;
  logic [31:0] reg_rdata, reg_wdata;

  logic [31:0] regs [16];
  logic [15:0] ctr = 16'h0;

  assign reg_rdata = (reg_idx == 4'd7) ? {ctr, ctr} : regs[reg_idx];
  assign reg_valid = reg_idx < 4'd12;

  mdio_dword_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .reset_active(reset_active),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .reg_idx(reg_idx), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_valid(reg_valid), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

  int checks = 0, errors = 0;
  logic [35:0] exp_q [$];

  bit   bwpend = 0, bwhalf = 0, brpend = 0, brhalf = 0;
  logic [15:0] bwbuf = '0;
  logic [31:0] brlatch = '0;

  logic exp_next = 1'b0, exp_oe = 1'b0, mdc_seen = 1'b1;
  int   since = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mdc != mdc_seen) begin
      mdc_seen <= mdc;
      since    <= 0;
      exp_oe   <= exp_next;
    end else if (since < 100) begin
      since <= since + 1;
    end
  end

  always @(negedge clk) begin
    ctr <= ctr + 1'b1;
    if (rst_n && since >= 1) chk("R6 oe window", {31'h0, mdio_oe}, {31'h0, exp_oe});
    if (reg_wr) begin
      if (exp_q.size() == 0) chk("R2 R4 unexpected write", {28'h0, reg_idx}, 32'hFFFF_FFFF);
      else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        chk("R4 write index", {28'h0, reg_idx}, {28'h0, e[35:32]});
        chk("R4 write data", reg_wdata, e[31:0]);
      end
      regs[reg_idx] <= reg_wdata;
    end
  end

  task automatic frame(input logic [1:0] stb, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd, input bit drv,
                       output logic [15:0] rd, output logic ta);
    logic [63:0] fb;
    logic bus;
    bit rdfr;
    rdfr = (op == 2'b10);
    fb = {32'hFFFF_FFFF, stb, op, phy, ra, rdfr ? 2'b11 : 2'b10, rdfr ? 16'hFFFF : wd};
    rd = '0; ta = 1'b1;
    for (int i = 0; i < 66; i++) begin
      @(negedge clk);
      mdc = 1'b0;
      mdio_i = (i < 64) ? fb[63-i] : 1'b1;
      exp_next = drv && i >= 47 && i <= 63;
      repeat (4) @(negedge clk);
      bus = mdio_oe ? mdio_o : 1'b1;
      if (i == 47) ta = bus;
      if (i >= 48 && i < 64) rd[63-i] = bus;
      mdc = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [4:0] ra, input logic [15:0] wd, input logic [4:0] phy = 5'd1);
    logic [15:0] r; logic t;
    if (phy == 5'd1 && !reset_active) begin
      if (!bwpend) begin bwpend = 1; bwhalf = ra[0]; bwbuf = wd; end
      else if (bwhalf != ra[0]) begin
        exp_q.push_back({ra[4:1], ra[0] ? {wd, bwbuf} : {bwbuf, wd}});
        bwpend = 0;
      end
    end
    frame(2'b01, 2'b01, phy, ra, wd, 0, r, t);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [4:0] ra, input string tag, output logic [15:0] got);
    logic t; logic [31:0] s; logic [15:0] e; bit cap;
    cap = 0;
    if (reset_active) e = 16'h0;
    else if (brpend && brhalf != ra[0]) begin
      e = ra[0] ? brlatch[31:16] : brlatch[15:0];
      brpend = 0;
    end else begin
      s = (ra[4:1] < 4'd12) ? regs[ra[4:1]] : 32'h0;
      cap = (ra[4:1] == 4'd7);
      brlatch = s; brpend = 1; brhalf = ra[0];
      e = ra[0] ? s[31:16] : s[15:0];
    end
    frame(2'b01, 2'b10, 5'd1, ra, 16'h0, 1, got, t);
    chk("R6 turnaround bit", {31'h0, t}, 32'h0);
    if (cap) brlatch = {got, got};
    else chk(tag, {16'h0, got}, {16'h0, e});
    if (reset_active) begin brpend = 0; bwpend = 0; end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_reset();
    reset_active = 1'b1;
    repeat (12) @(negedge clk);
    reset_active = 1'b0;
    brpend = 0; bwpend = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a, b, r; logic t;
    for (int k = 0; k < 16; k++) regs[k] = 32'h0101_0101 * k;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 reset oe", {31'h0, mdio_oe}, 32'h0);
    chk("R4 reset wr", {31'h0, reg_wr}, 32'h0);
    chk("R7 reset rd", {31'h0, reg_rd}, 32'h0);

    do_write(5'd4, 16'hCCDD); do_write(5'd5, 16'hAABB);
    do_write(5'd7, 16'h1234); do_write(5'd6, 16'h5678);
    do_write(5'd8, 16'h1111); do_write(5'd8, 16'h2222); do_write(5'd9, 16'h3333);
    chk("R4 R5 write count", exp_q.size(), 0);

    do_read(5'd4, "R1 R7 lo first", r); do_read(5'd5, "R7 hi second", r);
    do_read(5'd7, "R7 hi first", r);    do_read(5'd6, "R7 lo second", r);
    do_read(5'd9, "R5 kept pending", r); do_read(5'd9, "R7 same half again", r);
    do_read(5'd8, "R5 first half kept", r);
    do_read(5'd26, "R8 unused lo", r);  do_read(5'd27, "R8 unused hi", r);

    frame(2'b01, 2'b10, 5'd1, 5'd14, 16'h0, 1, a, t);
    frame(2'b01, 2'b10, 5'd1, 5'd15, 16'h0, 1, b, t);
    chk("R7 coherent lo-hi", {16'h0, b}, {16'h0, a});
    frame(2'b01, 2'b10, 5'd1, 5'd15, 16'h0, 1, a, t);
    frame(2'b01, 2'b10, 5'd1, 5'd14, 16'h0, 1, b, t);
    chk("R7 coherent hi-lo", {16'h0, b}, {16'h0, a});

    do_write(5'd10, 16'hDEAD, 5'd3); do_write(5'd11, 16'hBEEF, 5'd3);
    frame(2'b01, 2'b11, 5'd1, 5'd10, 16'h0F0F, 0, r, t);
    frame(2'b00, 2'b01, 5'd1, 5'd10, 16'h0F0F, 0, r, t);
    frame(2'b01, 2'b10, 5'd2, 5'd4, 16'h0, 0, r, t);
    do_read(5'd4, "R2 recovers after bad frames", r);
    do_read(5'd5, "R2 R7 pair after bad frames", r);

    do_read(5'd4, "R9 lo before reset", r);
    pulse_reset();
    do_write(5'd5, 16'hBEEF); do_write(5'd4, 16'h0001);
    do_read(5'd5, "R9 fresh capture after reset", r);
    do_read(5'd4, "R9 second half from latch", r);

    do_write(5'd10, 16'hA5A5);
    pulse_reset();
    do_write(5'd11, 16'h5A5A); do_write(5'd10, 16'h0F0F);

    reset_active = 1'b1;
    do_read(5'd4, "R9 read during reset", r);
    do_write(5'd12, 16'h7777); do_write(5'd13, 16'h8888);
    reset_active = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 R9 pending writes", exp_q.size(), 0);
    chk("R9 regs idx6 untouched", regs[6], 32'h0606_0606);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule